// File: doc/BRIEF.md
# Diagnostic Output Selector with Clock Bypass

This block drives a single diagnostic pin of a clock synthesizer's digital section. A 3-bit test code chooses what the pin shows: the serial configuration register's outgoing bit, a fixed high or low level, the reference clock divided by 16, the terminal pulse of the feedback counter, the synthesized output clock, or that output clock divided by 4. The block also holds the feedback counter and the output post-divider. Together with the pin, they make up the digital path from which the synthesized clock is built.

All clocks are represented as single-cycle tick enables on one fast system clock. `vco_tick` marks rising edges of the oscillator clock, `ref_tick` marks rising edges of the reference clock, and `sclk_tick` marks rising edges of the serial programming clock. One test code puts the block into a bypass mode for board-level debug. In that mode the serial clock, and not the oscillator, drives both the feedback counter and the post-divider. Moves into and out of bypass pass through a two-stage source handover, so that neither divider ever sees ticks from both sources, or a partial one.

Top module: `diag_select_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `diag_out` and `main_out` are 0. The feedback counter holds 0, and the oscillator is the selected tick source.
- R2: `diag_out` depends on the test code as follows. Code 3'b000 shows `shift_bit`. Code 3'b001 drives a constant 1. Code 3'b101 drives a constant 0.
- R3: Code 3'b010 shows the reference clock divided by 16. This level toggles on every 8th `ref_tick`, counted from reset.
- R4: Code 3'b011 shows the feedback pulse. The pulse is high for one cycle after a selected tick that finds the counter at 0; that tick reloads the counter with `m_value`-1. Every other selected tick decrements the counter. The first selected tick after reset therefore pulses.
- R5: When `m_value` is 0, the counter is forced to 0 and no pulse is produced.
- R6: `main_out` toggles on every 2^`n_sel` selected ticks, with `n_sel` values 0..3. It changes in no other cycle.
- R7: Code 3'b100 shows `main_out`. Code 3'b111 shows a level that toggles on every second rising edge of `main_out`.
- R8: Code 3'b110 is bypass. `sclk_tick` replaces `vco_tick` as the source for both the counter and the post-divider, and `diag_out` shows the feedback pulse.
- R9: The bypass request is registered one cycle after the code changes. The old tick source is then disabled for one cycle, with no source active, and only after that is the new source enabled. Ticks that arrive during that cycle are dropped.
- R10: `diag_out` is registered. It reflects the code and sources present one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| test_code | input | 3 | Diagnostic source select, 3'b110 = bypass |
| m_value | input | 9 | Feedback counter reload value |
| n_sel | input | 2 | Post-divider select, toggle every 2^n ticks |
| vco_tick | input | 1 | Oscillator rising-edge enable |
| ref_tick | input | 1 | Reference clock rising-edge enable |
| sclk_tick | input | 1 | Serial clock rising-edge enable |
| shift_bit | input | 1 | Outgoing bit of the serial shift register |
| diag_out | output | 1 | Diagnostic output |
| main_out | output | 1 | Post-divided output clock |

## Verification
The hardest situation to reach is the handover window of a bypass switch. Both tick sources must be active around the code change to show that ticks are dropped during the empty cycle. The stimulus therefore holds `vco_tick` and `sclk_tick` high, or toggles them at random, across every entry into and exit from code 3'b110. The bench model tracks the handover state and compares `main_out` on each of those cycles. The stimulus also sets `m_value` to 0 while ticks are running, and changes `n_sel` in the middle of a count.

// File: rtl/diag_pkg.sv
package diag_pkg;
  typedef enum logic [2:0] {
    SEL_SHIFT   = 3'b000,
    SEL_ONE     = 3'b001,
    SEL_REF16   = 3'b010,
    SEL_FBPULSE = 3'b011,
    SEL_MAIN    = 3'b100,
    SEL_ZERO    = 3'b101,
    SEL_BYPASS  = 3'b110,
    SEL_MAIN4   = 3'b111
  } diag_sel_e;
endpackage

// File: rtl/clk_steer.sv
module clk_steer (
  input  logic clk,
  input  logic rst,
  input  logic bypass_req,
  input  logic vco_tick,
  input  logic sclk_tick,
  output logic en_vco,
  output logic en_byp,
  output logic div_tick
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      en_vco <= 1'b1;
      en_byp <= 1'b0;
    end else begin
      req_q <= bypass_req;
      if (req_q) begin
        if (en_vco) en_vco <= 1'b0;
        else if (!en_byp) en_byp <= 1'b1;
      end else begin
        if (en_byp) en_byp <= 1'b0;
        else if (!en_vco) en_vco <= 1'b1;
      end
    end
  end

  assign div_tick = (en_vco & vco_tick) | (en_byp & sclk_tick);
endmodule

// File: rtl/fb_counter.sv
module fb_counter #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [M_W-1:0] m_value,
  output logic           pulse
);
  logic [M_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (m_value == '0) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      if (cnt == '0) begin
        cnt   <= m_value - 1'b1;
        pulse <= 1'b1;
      end else begin
        cnt   <= cnt - 1'b1;
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/post_div.sv
module post_div #(
  parameter int NSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NSEL_W-1:0] n_sel,
  output logic              level
);
  localparam int CNT_W = (1 << NSEL_W) - 1;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   limit;

  always_comb limit = ({{CNT_W{1'b0}}, 1'b1} << n_sel) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (tick) begin
      if ({1'b0, cnt} >= limit) begin
        cnt   <= '0;
        level <= ~level;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic level
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (tick) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        level <= ~level;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/diag_select_top.sv
module diag_select_top #(
  parameter int M_W     = 9,
  parameter int NSEL_W  = 2,
  parameter int REF_DIV = 16,
  parameter int OUT_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        test_code,
  input  logic [M_W-1:0]    m_value,
  input  logic [NSEL_W-1:0] n_sel,
  input  logic              vco_tick,
  input  logic              ref_tick,
  input  logic              sclk_tick,
  input  logic              shift_bit,
  output logic              diag_out,
  output logic              main_out
);
  import diag_pkg::*;

  logic      en_vco, en_byp, div_tick;
  logic      fb_pulse, ref_div, main_div, main_q, main_rise;
  logic      diag_d;
  diag_sel_e sel;

  assign sel = diag_sel_e'(test_code);

  clk_steer u_steer (
    .clk(clk), .rst(rst), .bypass_req(sel == SEL_BYPASS),
    .vco_tick(vco_tick), .sclk_tick(sclk_tick),
    .en_vco(en_vco), .en_byp(en_byp), .div_tick(div_tick)
  );

  fb_counter #(.M_W(M_W)) u_fb (
    .clk(clk), .rst(rst), .tick(div_tick), .m_value(m_value), .pulse(fb_pulse)
  );

  post_div #(.NSEL_W(NSEL_W)) u_post (
    .clk(clk), .rst(rst), .tick(div_tick), .n_sel(n_sel), .level(main_out)
  );

  tick_prescaler #(.DIV(REF_DIV)) u_ref_pre (
    .clk(clk), .rst(rst), .tick(ref_tick), .level(ref_div)
  );

  always_ff @(posedge clk) begin
    if (rst) main_q <= 1'b0;
    else     main_q <= main_out;
  end
  assign main_rise = main_out & ~main_q;

  tick_prescaler #(.DIV(OUT_DIV)) u_out_pre (
    .clk(clk), .rst(rst), .tick(main_rise), .level(main_div)
  );

  always_comb begin
    unique case (sel)
      SEL_SHIFT:   diag_d = shift_bit;
      SEL_ONE:     diag_d = 1'b1;
      SEL_REF16:   diag_d = ref_div;
      SEL_FBPULSE: diag_d = fb_pulse;
      SEL_MAIN:    diag_d = main_out;
      SEL_ZERO:    diag_d = 1'b0;
      SEL_BYPASS:  diag_d = fb_pulse;
      SEL_MAIN4:   diag_d = main_div;
      default:     diag_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) diag_out <= 1'b0;
    else     diag_out <= diag_d;
  end
endmodule

// File: rtl/diag_select_chk.sv
module diag_select_chk #(
  parameter int M_W = 9
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     test_code,
  input logic [M_W-1:0] m_value,
  input logic           diag_out,
  input logic           main_out,
  input logic           en_vco,
  input logic           en_byp,
  input logic           div_tick,
  input logic           fb_pulse
);
  assert_one_source_R9: assert property (@(posedge clk) disable iff (rst)
    !(en_vco && en_byp));

  assert_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(m_value) == '0) |-> !fb_pulse);

  assert_main_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(div_tick)) |-> $stable(main_out));

  assert_const_one_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(test_code) == 3'b001) |-> diag_out);

  assert_const_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(test_code) == 3'b101) |-> !diag_out);
endmodule

bind diag_select_top diag_select_chk #(.M_W(M_W)) u_chk (
  .clk(clk), .rst(rst), .test_code(test_code), .m_value(m_value),
  .diag_out(diag_out), .main_out(main_out), .en_vco(en_vco),
  .en_byp(en_byp), .div_tick(div_tick), .fb_pulse(fb_pulse)
);

// File: tb/test_diag_select_top.sv
`timescale 1ns/1ps
module test_diag_select_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] test_code = 3'b000;
  logic [8:0] m_value = 9'd5;
  logic [1:0] n_sel = 2'd0;
  logic       vco_tick = 1'b0, ref_tick = 1'b0, sclk_tick = 1'b0, shift_bit = 1'b0;
  logic       diag_out, main_out;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  diag_select_top i_diag_select_top (
    .clk(clk), .rst(rst), .test_code(test_code), .m_value(m_value),
    .n_sel(n_sel), .vco_tick(vco_tick), .ref_tick(ref_tick),
    .sclk_tick(sclk_tick), .shift_bit(shift_bit),
    .diag_out(diag_out), .main_out(main_out)
  );

  // behavioural reference model
  int  m_cnt, n_cnt, r_cnt, q_cnt;
  bit  m_req, m_env, m_enb, m_pulse, m_main, m_mainq, m_r16, m_q4, m_diag;
  int  prev_code;

  always @(posedge clk) begin
    bit tick, o_pulse, o_main, o_mainq, o_r16, o_q4, o_req;
    if (rst) begin
      m_cnt = 0; n_cnt = 0; r_cnt = 0; q_cnt = 0;
      m_req = 0; m_env = 1; m_enb = 0; m_pulse = 0; m_main = 0;
      m_mainq = 0; m_r16 = 0; m_q4 = 0; m_diag = 0;
    end else begin
      o_pulse = m_pulse; o_main = m_main; o_mainq = m_mainq;
      o_r16 = m_r16; o_q4 = m_q4; o_req = m_req;
      tick = (m_env && vco_tick) || (m_enb && sclk_tick);
      if (m_value == 0) begin m_cnt = 0; m_pulse = 0; end
      else if (tick) begin
        if (m_cnt == 0) begin m_pulse = 1; m_cnt = m_value - 1; end
        else begin m_cnt--; m_pulse = 0; end
      end else m_pulse = 0;
      if (tick) begin
        if (n_cnt >= (1 << n_sel) - 1) begin n_cnt = 0; m_main = !m_main; end
        else n_cnt++;
      end
      if (ref_tick) begin
        if (r_cnt == 7) begin r_cnt = 0; m_r16 = !m_r16; end else r_cnt++;
      end
      if (o_main && !o_mainq) begin
        if (q_cnt == 1) begin q_cnt = 0; m_q4 = !m_q4; end else q_cnt++;
      end
      m_mainq = o_main;
      case (test_code)
        3'b000: m_diag = shift_bit;
        3'b001: m_diag = 1;
        3'b010: m_diag = o_r16;
        3'b011: m_diag = o_pulse;
        3'b100: m_diag = o_main;
        3'b101: m_diag = 0;
        3'b110: m_diag = o_pulse;
        default: m_diag = o_q4;
      endcase
      if (o_req) begin
        if (m_env) m_env = 0; else if (!m_enb) m_enb = 1;
      end else begin
        if (m_enb) m_enb = 0; else if (!m_env) m_env = 1;
      end
      m_req = (test_code == 3'b110);
    end
  end

  task automatic check(input string req, input bit act, input bit exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string diag_req(input int code, input int mv);
    case (code)
      0, 1, 5: return "R2";
      2:       return "R3";
      3:       return (mv == 0) ? "R5" : "R4";
      6:       return "R8";
      default: return "R7";
    endcase
  endfunction

  // compare at negedge, then drive the next inputs
  task automatic run(input int cycles, input int code, input int vmode, input int smode);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (prev_code != int'(test_code))
        check("R10", diag_out, m_diag, "diag after code change");
      else
        check(diag_req(int'(test_code), int'(m_value)), diag_out, m_diag, "diag_out");
      check((!m_env && !m_enb) ? "R9" : "R6", main_out, m_main, "main_out");
      prev_code = int'(test_code);
      test_code = 3'(code);
      shift_bit = 1'($urandom);
      ref_tick  = 1'($urandom);
      vco_tick  = (vmode == 2) ? 1'($urandom) : 1'(vmode);
      sclk_tick = (smode == 2) ? 1'($urandom) : 1'(smode);
    end
  endtask

  initial begin
    prev_code = 0;
    repeat (3) @(negedge clk);
    check("R1", diag_out, 1'b0, "diag in reset");
    check("R1", main_out, 1'b0, "main in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", diag_out, 1'b0, "diag after reset");
    check("R1", main_out, 1'b0, "main after reset");
    run(40, 0, 2, 0);          // R2 shift bit
    run(20, 1, 1, 0);          // R2 one
    run(20, 5, 1, 0);          // R2 zero
    run(200, 2, 2, 2);         // R3
    for (int n = 0; n < 4; n++) begin
      n_sel = 2'(n);
      run(60, 3, 1, 0);        // R4 R6
      run(60, 4, 2, 0);        // R7 main
      run(80, 7, 1, 0);        // R7 div4
    end
    m_value = 9'd1;  run(30, 3, 2, 0);
    m_value = 9'd0;  run(40, 3, 1, 0);   // R5
    m_value = 9'd3;  run(30, 3, 1, 0);
    m_value = 9'd511; run(600, 3, 1, 0);
    m_value = 9'd4; n_sel = 2'd0;
    for (int k = 0; k < 6; k++) begin
      run(30, 6, 1, 1);        // R8/R9 both sources active
      run(30, 3, 1, 1);
      run(40, 6, 2, 2);
      n_sel = 2'(k);
      run(40, 4, 2, 2);
    end
    m_value = 9'd0; run(30, 6, 1, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule